// File: doc/BRIEF.md
# Multiplexed LED Grayscale Scan Driver

This block turns stored 8-bit pixels into the serial bit streams, latch strobes and PWM clocks needed by rows of 16-channel constant-current LED drivers. A row is lit while a row-select line is active. For each row, the block reads two frame buffers in parallel through a single shared read address. Each buffer feeds its own lookup port, which expands the pixel to 12-bit intensity. The block then mixes the two results under a mode input and shifts the words, most significant bit first, into every serial lane on a shared shift clock.

After a row is shifted, the block raises blank and pulses the latch. It then switches the row select and lowers blank for exactly one full 12-bit PWM period of the grayscale clock. The next row follows. After the last row, the block issues a one-cycle frame pulse and increments a 16-bit frame counter. The shift clock and the grayscale clock are each a power-of-two division of the system clock. The next 12-bit word is fetched while the current one is shifting, so the serial stream has no gaps.

Top module: `led_scan_driver`

## Requirements
- R1: While reset is asserted: blank_o=1; xlat_o, sclk_o, gsclk_o, vsync_o, mode_o and sin_o are 0; row_sel_o and frame_cnt_o are 0.
- R2: For each row, each lane i carries NCOL*CH words of INT_W bits on rising sclk_o edges, MSB first. Word w uses color index c=w/CH (0 blue, 1 green, 2 red) and channel CH-1-(w mod CH). The word is read at frame-buffer address ((row*LANES+i)*CH+channel)*NCOL+c.
- R3: Each lookup port address equals the 8-bit data of its frame buffer. Frame-buffer data and lookup data each arrive one clock after their address.
- R4: mix_i selects the shifted word from the two lookup results a and b: 0 gives a, 1 gives b, 2 gives (a+b)/2 rounded down, and 3 gives a+b saturated at all ones.
- R5: sclk_o has a period of 2^SCLK_DIV_LOG2 system cycles, is high during the second half of each period, and toggles only while blank_o is high.
- R6: After the last bit of a row, xlat_o is high for exactly 2^SCLK_DIV_LOG2 cycles, with blank_o high throughout.
- R7: row_sel_o is one-hot or zero. It changes only while blank_o is high, and it equals 1<<row when blank_o falls.
- R8: Each blank-low interval lasts exactly 2^PWM_W gsclk_o periods of 2^(GS_DIV_LOG2+1) cycles each, and contains 2^PWM_W rising gsclk_o edges.
- R9: Rows are displayed in the order 0,1,...,ROWS-1 and then wrap to 0.
- R10: vsync_o is high for one cycle, on the cycle blank rises after row ROWS-1, and frame_cnt_o increments by one on that same cycle.
- R11: mode_o stays 0 (grayscale data on the serial lines).
- R12: gsclk_o is low whenever blank_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mix_i | input | 2 | Selects how the two lookup results are combined |
| fb_addr_o | output | FB_AW | Read address shared by both frame buffers |
| fb0_data_i | input | PIX_W | Frame buffer 0 read data |
| fb1_data_i | input | PIX_W | Frame buffer 1 read data |
| lut0_addr_o | output | PIX_W | Lookup 0 read address |
| lut0_data_i | input | INT_W | Lookup 0 read data |
| lut1_addr_o | output | PIX_W | Lookup 1 read address |
| lut1_data_i | input | INT_W | Lookup 1 read data |
| sclk_o | output | 1 | Serial shift clock to the driver chains |
| sin_o | output | LANES | Serial data, one line per driver chain |
| xlat_o | output | 1 | Latch strobe |
| blank_o | output | 1 | Blank, with outputs dark while high |
| gsclk_o | output | 1 | Grayscale PWM clock |
| mode_o | output | 1 | Serial data mode, 0 selects grayscale |
| row_sel_o | output | ROWS | One-hot row select |
| vsync_o | output | 1 | One-cycle end-of-frame pulse |
| frame_cnt_o | output | 16 | Frame counter |

## Verification
A wrong word index, lane index or fetch pipeline stage shows up as a wrong bit in the captured row vectors, and it appears on the first xlat pulse after reset. A sequencer that miscounts shows up within the same row as a wrong bit count, a wrong latch width, or a blank-low interval whose gsclk edge count is not 4096. Row-order and frame-counter faults appear at the next blank-low interval or at the next frame pulse. The bench runs one frame in each of the four mix settings.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
    typedef enum logic [2:0] {
        ST_PREP   = 3'd0,
        ST_SHIFT  = 3'd1,
        ST_LATCH  = 3'd2,
        ST_SELECT = 3'd3,
        ST_PWM    = 3'd4
    } scan_state_e;

    localparam logic [1:0] MIX_A   = 2'd0;
    localparam logic [1:0] MIX_B   = 2'd1;
    localparam logic [1:0] MIX_AVG = 2'd2;
    localparam logic [1:0] MIX_SUM = 2'd3;

    localparam logic SERIAL_MODE_GRAY = 1'b0;
endpackage

// File: rtl/led_scan_fetch.sv
module led_scan_fetch
    import led_scan_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int CH     = 16,
    parameter int NCOL   = 3,
    parameter int ROWS   = 12,
    parameter int PIX_W  = 8,
    parameter int INT_W  = 12,
    parameter int FB_AW  = 11,
    parameter int ROW_W  = 4,
    parameter int WORD_W = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_i,
    input  logic [WORD_W-1:0]                 word_i,
    input  logic [ROW_W-1:0]                  row_i,
    input  logic [1:0]                        mix_i,
    output logic [FB_AW-1:0]                  fb_addr_o,
    input  logic [PIX_W-1:0]                  fb0_data_i,
    input  logic [PIX_W-1:0]                  fb1_data_i,
    output logic [PIX_W-1:0]                  lut0_addr_o,
    output logic [PIX_W-1:0]                  lut1_addr_o,
    input  logic [INT_W-1:0]                  lut0_data_i,
    input  logic [INT_W-1:0]                  lut1_data_i,
    output logic [LANES-1:0][INT_W-1:0]       stage_o,
    output logic                              busy_o,
    output logic                              done_o
);
    localparam int PIPE = 3;
    localparam int FCW  = $clog2(LANES + PIPE + 1);
    localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1;

    typedef struct packed {
        logic                        active;
        logic [FCW-1:0]              fc;
        logic [WORD_W-1:0]           word;
        logic [ROW_W-1:0]            row;
        logic [FB_AW-1:0]            addr;
        logic [LANES-1:0][INT_W-1:0] stage;
        logic                        done;
    } fetch_t;

    fetch_t q, n;
    logic [INT_W:0]   sum;
    logic [INT_W-1:0] mixed;
    logic [LW-1:0]    cap_idx;
    int               chan, col, lane;

    assign lut0_addr_o = fb0_data_i;
    assign lut1_addr_o = fb1_data_i;

    always_comb begin
        sum = {1'b0, lut0_data_i} + {1'b0, lut1_data_i};
        case (mix_i)
            MIX_A:   mixed = lut0_data_i;
            MIX_B:   mixed = lut1_data_i;
            MIX_AVG: mixed = sum[INT_W:1];
            default: mixed = sum[INT_W] ? '1 : sum[INT_W-1:0];
        endcase
    end

    always_comb begin
        n       = q;
        n.done  = 1'b0;
        lane    = int'(q.fc);
        chan    = CH - 1 - (int'(q.word) % CH);
        col     = int'(q.word) / CH;
        cap_idx = LW'(lane - PIPE);
        if (start_i) begin
            n.active = 1'b1;
            n.fc     = '0;
            n.word   = word_i;
            n.row    = row_i;
        end else if (q.active) begin
            n.fc = q.fc + 1'b1;
            if (lane < LANES)
                n.addr = FB_AW'(((int'(q.row) * LANES + lane) * CH + chan) * NCOL + col);
            if (lane >= PIPE)
                n.stage[cap_idx] = mixed;
            if (lane == LANES + PIPE - 1) begin
                n.active = 1'b0;
                n.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign fb_addr_o = q.addr;
    assign stage_o   = q.stage;
    assign busy_o    = q.active;
    assign done_o    = q.done;

    a_r3_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !q.active);
    a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> $past(q.active));
endmodule

// File: rtl/led_scan_serializer.sv
module led_scan_serializer #(
    parameter int LANES = 2,
    parameter int INT_W = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_i,
    input  logic                        shift_i,
    input  logic [LANES-1:0][INT_W-1:0] stage_i,
    output logic [LANES-1:0]            sin_o
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [INT_W-1:0] sh_d, sh_q;

        always_comb begin
            sh_d = sh_q;
            if (load_i)       sh_d = stage_i[l];
            else if (shift_i) sh_d = {sh_q[INT_W-2:0], 1'b0};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end

        assign sin_o[l] = sh_q[INT_W-1];
    end
endmodule

// File: rtl/led_scan_timing.sv
module led_scan_timing
    import led_scan_pkg::*;
#(
    parameter int ROWS          = 12,
    parameter int WORDS         = 48,
    parameter int INT_W         = 12,
    parameter int PWM_W         = 12,
    parameter int SCLK_DIV_LOG2 = 1,
    parameter int GS_DIV_LOG2   = 0,
    parameter int ROW_W         = 4,
    parameter int WORD_W        = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_done_i,
    output logic              fetch_start_o,
    output logic [WORD_W-1:0] fetch_word_o,
    output logic [ROW_W-1:0]  row_o,
    output logic              load_o,
    output logic              shift_o,
    output logic              sclk_o,
    output logic              xlat_o,
    output logic              blank_o,
    output logic              gsclk_o,
    output logic [ROWS-1:0]   row_sel_o,
    output logic              vsync_o,
    output logic [15:0]       frame_cnt_o
);
    localparam int BCW = (INT_W > 1) ? $clog2(INT_W) : 1;
    localparam int SDW = SCLK_DIV_LOG2;
    localparam int GDW = GS_DIV_LOG2 + 1;

    typedef struct packed {
        scan_state_e       st;
        logic [SDW-1:0]    dv;
        logic [BCW-1:0]    bc;
        logic [WORD_W-1:0] wc;
        logic [PWM_W-1:0]  gc;
        logic [GDW-1:0]    gdv;
        logic [ROW_W-1:0]  row;
        logic [ROWS-1:0]   sel;
        logic              vsync;
        logic [15:0]       frame;
        logic              fstart;
        logic [WORD_W-1:0] fword;
    } tstate_t;

    localparam tstate_t RESET_VAL = '{st: ST_PREP, fstart: 1'b1, default: '0};

    tstate_t q, n;

    always_comb begin
        n        = q;
        n.vsync  = 1'b0;
        n.fstart = 1'b0;
        load_o   = 1'b0;
        shift_o  = 1'b0;
        case (q.st)
            ST_PREP: begin
                if (fetch_done_i) begin
                    load_o = 1'b1;
                    n.st   = ST_SHIFT;
                    n.dv   = '0;
                    n.bc   = '0;
                    n.wc   = '0;
                    if (WORDS > 1) begin
                        n.fstart = 1'b1;
                        n.fword  = WORD_W'(1);
                    end
                end
            end
            ST_SHIFT: begin
                n.dv = q.dv + 1'b1;
                if (q.dv == '1) begin
                    if (q.bc == BCW'(INT_W - 1)) begin
                        n.bc = '0;
                        if (q.wc == WORD_W'(WORDS - 1)) begin
                            n.st = ST_LATCH;
                        end else begin
                            load_o = 1'b1;
                            n.wc   = q.wc + 1'b1;
                            if (int'(q.wc) + 2 < WORDS) begin
                                n.fstart = 1'b1;
                                n.fword  = WORD_W'(int'(q.wc) + 2);
                            end
                        end
                    end else begin
                        shift_o = 1'b1;
                        n.bc    = q.bc + 1'b1;
                    end
                end
            end
            ST_LATCH: begin
                n.dv = q.dv + 1'b1;
                if (q.dv == '1) begin
                    n.st         = ST_SELECT;
                    n.sel        = '0;
                    n.sel[q.row] = 1'b1;
                end
            end
            ST_SELECT: begin
                n.dv = q.dv + 1'b1;
                if (q.dv == '1) begin
                    n.st  = ST_PWM;
                    n.gdv = '0;
                    n.gc  = '0;
                end
            end
            default: begin
                n.gdv = q.gdv + 1'b1;
                if (q.gdv == '1) begin
                    n.gc = q.gc + 1'b1;
                    if (q.gc == '1) begin
                        n.st     = ST_PREP;
                        n.fstart = 1'b1;
                        n.fword  = '0;
                        if (q.row == ROW_W'(ROWS - 1)) begin
                            n.row   = '0;
                            n.vsync = 1'b1;
                            n.frame = q.frame + 16'd1;
                        end else begin
                            n.row = q.row + 1'b1;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= n;
    end

    assign fetch_start_o = q.fstart;
    assign fetch_word_o  = q.fword;
    assign row_o         = q.row;
    assign sclk_o        = (q.st == ST_SHIFT) && q.dv[SDW-1];
    assign xlat_o        = (q.st == ST_LATCH);
    assign blank_o       = (q.st != ST_PWM);
    assign gsclk_o       = (q.st == ST_PWM) && q.gdv[GDW-1];
    assign row_sel_o     = q.sel;
    assign vsync_o       = q.vsync;
    assign frame_cnt_o   = q.frame;

    a_r5_sclk_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> blank_o);
    a_r6_xlat_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_o |-> blank_o);
    a_r7_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_sel_o));
    a_r7_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank_o && $past(!blank_o)) |-> $stable(row_sel_o));
    a_r10_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_o |-> (frame_cnt_o == $past(frame_cnt_o) + 16'd1));
    a_r10_vsync_single: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_o |=> !vsync_o);
    a_r12_gsclk_dark: assert property (@(posedge clk) disable iff (!rst_n)
        gsclk_o |-> !blank_o);
endmodule

// File: rtl/led_scan_driver.sv
module led_scan_driver
    import led_scan_pkg::*;
#(
    parameter int ROWS          = 12,
    parameter int LANES         = 2,
    parameter int CH            = 16,
    parameter int NCOL          = 3,
    parameter int PIX_W         = 8,
    parameter int INT_W         = 12,
    parameter int PWM_W         = 12,
    parameter int SCLK_DIV_LOG2 = 1,
    parameter int GS_DIV_LOG2   = 0,
    localparam int FB_AW        = $clog2(ROWS * LANES * CH * NCOL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mix_i,
    output logic [FB_AW-1:0] fb_addr_o,
    input  logic [PIX_W-1:0] fb0_data_i,
    input  logic [PIX_W-1:0] fb1_data_i,
    output logic [PIX_W-1:0] lut0_addr_o,
    input  logic [INT_W-1:0] lut0_data_i,
    output logic [PIX_W-1:0] lut1_addr_o,
    input  logic [INT_W-1:0] lut1_data_i,
    output logic             sclk_o,
    output logic [LANES-1:0] sin_o,
    output logic             xlat_o,
    output logic             blank_o,
    output logic             gsclk_o,
    output logic             mode_o,
    output logic [ROWS-1:0]  row_sel_o,
    output logic             vsync_o,
    output logic [15:0]      frame_cnt_o
);
    localparam int WORDS  = NCOL * CH;
    localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1;

    logic                        fetch_start, fetch_busy, fetch_done;
    logic [WORD_W-1:0]           fetch_word;
    logic [ROW_W-1:0]            cur_row;
    logic                        load, shift;
    logic [LANES-1:0][INT_W-1:0] stage;

    led_scan_timing #(
        .ROWS(ROWS), .WORDS(WORDS), .INT_W(INT_W), .PWM_W(PWM_W),
        .SCLK_DIV_LOG2(SCLK_DIV_LOG2), .GS_DIV_LOG2(GS_DIV_LOG2),
        .ROW_W(ROW_W), .WORD_W(WORD_W)
    ) u_timing (
        .clk(clk), .rst_n(rst_n),
        .fetch_done_i(fetch_done), .fetch_start_o(fetch_start),
        .fetch_word_o(fetch_word), .row_o(cur_row),
        .load_o(load), .shift_o(shift),
        .sclk_o(sclk_o), .xlat_o(xlat_o), .blank_o(blank_o), .gsclk_o(gsclk_o),
        .row_sel_o(row_sel_o), .vsync_o(vsync_o), .frame_cnt_o(frame_cnt_o)
    );

    led_scan_fetch #(
        .LANES(LANES), .CH(CH), .NCOL(NCOL), .ROWS(ROWS), .PIX_W(PIX_W),
        .INT_W(INT_W), .FB_AW(FB_AW), .ROW_W(ROW_W), .WORD_W(WORD_W)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .start_i(fetch_start), .word_i(fetch_word), .row_i(cur_row), .mix_i(mix_i),
        .fb_addr_o(fb_addr_o), .fb0_data_i(fb0_data_i), .fb1_data_i(fb1_data_i),
        .lut0_addr_o(lut0_addr_o), .lut1_addr_o(lut1_addr_o),
        .lut0_data_i(lut0_data_i), .lut1_data_i(lut1_data_i),
        .stage_o(stage), .busy_o(fetch_busy), .done_o(fetch_done)
    );

    led_scan_serializer #(.LANES(LANES), .INT_W(INT_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .load_i(load), .shift_i(shift),
        .stage_i(stage), .sin_o(sin_o)
    );

    assign mode_o = SERIAL_MODE_GRAY;

    a_r2_load_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !fetch_busy);
    a_r2_fetch_fits_word: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> !fetch_start);
endmodule

// File: tb/led_scan_driver_tb.sv
`timescale 1ns/1ps
module led_scan_driver_tb;
    localparam int ROWS = 3, LANES = 2, CH = 4, NCOL = 3, PIX_W = 8, INT_W = 12;
    localparam int PWM_W = 12, SDIV = 1, GDIV = 0;
    localparam int WORDS = NCOL * CH;
    localparam int BITS = WORDS * INT_W;
    localparam int FB_AW = $clog2(ROWS * LANES * CH * NCOL);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mix = 2'd0;
    logic [FB_AW-1:0] fb_addr;
    logic [PIX_W-1:0] fb0_data = '0, fb1_data = '0, lut0_addr, lut1_addr;
    logic [INT_W-1:0] lut0_data = '0, lut1_data = '0;
    logic sclk, xlat, blank, gsclk, mode, vsync;
    logic [LANES-1:0] sin;
    logic [ROWS-1:0] row_sel;
    logic [15:0] frame_cnt;

    int checks = 0, errors = 0;
    bit run = 1'b0, finished = 1'b0;

    always #10 clk = ~clk;

    led_scan_driver #(
        .ROWS(ROWS), .LANES(LANES), .CH(CH), .NCOL(NCOL), .PIX_W(PIX_W), .INT_W(INT_W),
        .PWM_W(PWM_W), .SCLK_DIV_LOG2(SDIV), .GS_DIV_LOG2(GDIV)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .mix_i(mix), .fb_addr_o(fb_addr),
        .fb0_data_i(fb0_data), .fb1_data_i(fb1_data),
        .lut0_addr_o(lut0_addr), .lut0_data_i(lut0_data),
        .lut1_addr_o(lut1_addr), .lut1_data_i(lut1_data),
        .sclk_o(sclk), .sin_o(sin), .xlat_o(xlat), .blank_o(blank), .gsclk_o(gsclk),
        .mode_o(mode), .row_sel_o(row_sel), .vsync_o(vsync), .frame_cnt_o(frame_cnt)
    );

    function automatic int f0(int a); return (a * 37 + 11) % 256; endfunction
    function automatic int f1(int a); return (a * 91 + 200) % 256; endfunction
    function automatic int g0(int v); return ((v << 4) | (v >> 4)) % 4096; endfunction
    function automatic int g1(int v); return (v * 13 + 5) % 4096; endfunction

    // R3: one-cycle frame-buffer and lookup read models
    always @(posedge clk) begin
        fb0_data  <= PIX_W'(f0(int'(fb_addr)));
        fb1_data  <= PIX_W'(f1(int'(fb_addr)));
        lut0_data <= INT_W'(g0(int'(lut0_addr)));
        lut1_data <= INT_W'(g1(int'(lut1_addr)));
    end

    function automatic int blend(int m, int a, int b);
        case (m)
            0: return a;
            1: return b;
            2: return (a + b) / 2;
            default: return (a + b > 4095) ? 4095 : a + b;
        endcase
    endfunction

    function automatic logic [BITS-1:0] exp_bits(int row, int lane, int m);
        logic [BITS-1:0] r = '0;
        for (int w = 0; w < WORDS; w++) begin
            int a = ((row * LANES + lane) * CH + (CH - 1 - w % CH)) * NCOL + w / CH;
            int v = blend(m, g0(f0(a)), g1(f1(a)));
            r = (r << INT_W) | BITS'(v);
        end
        return r;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_vec(string req, logic [BITS-1:0] act, logic [BITS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor state
    logic [BITS-1:0] cap [LANES];
    int nbits = 0, xlat_w = 0, gs_cnt = 0, low_cnt = 0;
    int exp_row = 0, frames = 0, cur_mix = 0;
    bit expect_vs = 0, v_sclk = 0, v_xlat = 0, v_sel = 0, v_gs = 0, v_mode = 0, v_vs = 0;
    logic p_sclk = 0, p_xlat = 0, p_blank = 1, p_gs = 0, p_vs = 0;
    logic [ROWS-1:0] p_sel = '0;

    always @(negedge clk) begin
        if (run) begin
            if (sclk && !p_sclk) begin
                for (int l = 0; l < LANES; l++) cap[l] = {cap[l][BITS-2:0], sin[l]};
                nbits++;
            end
            if (sclk && !blank) v_sclk = 1;
            if (xlat && !blank) v_xlat = 1;
            if (blank && gsclk) v_gs = 1;
            if (mode !== 1'b0) v_mode = 1;
            if (vsync && p_vs) v_vs = 1;
            if (xlat) xlat_w++;
            if (!xlat && p_xlat) begin
                chk(xlat_w == 2 ** SDIV, "R6 xlat width", xlat_w, 2 ** SDIV);
                chk(nbits == BITS, "R2 bits per row", nbits, BITS);
                for (int l = 0; l < LANES; l++)
                    chk_vec(cur_mix == 0 ? "R2 R3 row data" : "R4 mixed row data",
                            cap[l], exp_bits(exp_row, l, cur_mix));
                xlat_w = 0;
                nbits  = 0;
            end
            if (!blank) begin
                low_cnt++;
                if (gsclk && !p_gs) gs_cnt++;
                if (!p_blank && row_sel != p_sel) v_sel = 1;
            end
            if (!blank && p_blank)
                chk(row_sel == (ROWS'(1) << exp_row), "R7 R9 row select", row_sel, 1 << exp_row);
            if (blank && !p_blank) begin
                chk(gs_cnt == 2 ** PWM_W, "R8 gsclk edges", gs_cnt, 2 ** PWM_W);
                chk(low_cnt == (2 ** PWM_W) * (2 ** (GDIV + 1)), "R8 blank-low length",
                    low_cnt, (2 ** PWM_W) * (2 ** (GDIV + 1)));
                chk(!v_sclk, "R5 sclk outside blank", v_sclk, 0);
                chk(!v_xlat, "R6 xlat outside blank", v_xlat, 0);
                chk(!v_sel, "R7 row select moved while lit", v_sel, 0);
                chk(!v_gs, "R12 gsclk while blank", v_gs, 0);
                chk(!v_mode, "R11 mode low", v_mode, 0);
                gs_cnt  = 0;
                low_cnt = 0;
                exp_row++;
                if (exp_row == ROWS) begin
                    exp_row   = 0;
                    frames++;
                    expect_vs = 1;
                end else begin
                    chk(!vsync, "R10 no vsync mid-frame", vsync, 0);
                end
            end
            if (vsync) begin
                chk(expect_vs, "R10 vsync after last row", expect_vs, 1);
                chk(frame_cnt == 16'(frames), "R10 frame count", frame_cnt, frames);
                expect_vs = 0;
            end
            p_sclk  = sclk;
            p_xlat  = xlat;
            p_blank = blank;
            p_gs    = gsclk;
            p_vs    = vsync;
            p_sel   = row_sel;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(blank === 1'b1, "R1 blank in reset", blank, 1);
        chk({xlat, sclk, gsclk, vsync, mode} === 5'b0, "R1 strobes in reset",
            {xlat, sclk, gsclk, vsync, mode}, 0);
        chk(sin === '0, "R1 sin in reset", sin, 0);
        chk(row_sel === '0, "R1 row select in reset", row_sel, 0);
        chk(frame_cnt === 16'd0, "R1 frame counter in reset", frame_cnt, 0);
        rst_n = 1'b1;
        run   = 1'b1;
        for (int f = 0; f < 4; f++) begin
            mix     = 2'(f);
            cur_mix = f;
            @(posedge vsync);
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk(frames == 4, "R9 R10 frames completed", frames, 4);
        chk(!v_vs, "R10 vsync one cycle", v_vs, 0);
        chk(!v_mode, "R11 mode low", v_mode, 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", frames, 4);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule